// File: doc/BRIEF.md
# DCT Output Clipping and Bus Formatter

This block sits between the column stage of a two-dimensional cosine transform and the shared 12-bit data bus. It takes a wide signed result and saturates it to the range the current mode allows. In forward mode the result is a 12-bit coefficient that fills the whole bus. In inverse mode the result is an 8-bit or 9-bit pixel that is placed at the top of the bus, with the spare low bits driven to zero. The formatted word is registered, so it reaches the bus one cycle after the input is marked valid. An output-enable input is registered alongside the data and drives a separate pad-enable output.

A companion input path handles the other direction. It takes a 12-bit input bus word and turns it into a sign-extended value of the internal width. In forward mode it reads a pixel from the top 8 or 9 bits and drops the low bits. In inverse mode it reads the whole word as a 12-bit coefficient. All values are two's complement.

Top module: `clip_fmt_top`

## Requirements
- R1: In forward mode (`inv_i`=0), a result in the range -2048..2047 appears unchanged on `dout_o[11:0]` as a 12-bit two's complement coefficient.
- R2: In forward mode, a result above 2047 gives 12'h7FF, and a result below -2048 gives 12'h800.
- R3: In inverse mode with 8-bit pixels (`inv_i`=1, `pix9_i`=0), the result is clipped to -128..127 and placed on `dout_o[11:4]`, and `dout_o[3:0]` is 0.
- R4: In inverse mode with 9-bit pixels (`inv_i`=1, `pix9_i`=1), the result is clipped to -256..255 and placed on `dout_o[11:3]`, and `dout_o[2:0]` is 0.
- R5: `dout_vld_o` is `res_vld_i` delayed by one cycle. `dout_o` changes only in the cycle after `res_vld_i` is high, and otherwise holds its value.
- R6: `bus_en_o` is `oe_i` delayed by one cycle. `oe_i` has no effect on `dout_o` or `dout_vld_o`.
- R7: While `rst` is high, at the clock edge `dout_o`, `dout_vld_o`, `bus_en_o`, `sx_o` and `sx_vld_o` all go to 0.
- R8: In the input path, in forward mode with 8-bit pixels, `sx_o` one cycle after `din_vld_i` is `din_i[11:4]` sign-extended to 16 bits. `din_i[3:0]` is ignored.
- R9: In the input path, in forward mode with 9-bit pixels, `sx_o` is `din_i[11:3]` sign-extended to 16 bits. `din_i[2:0]` is ignored.
- R10: In the input path, in inverse mode, `sx_o` is all of `din_i[11:0]` sign-extended to 16 bits. `sx_vld_o` is `din_vld_i` delayed by one cycle, and `sx_o` holds its value when `din_vld_i` is low.
- R11: In forward mode, `pix9_i` has no effect on `dout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_i | input | 16 | Signed result from the column transform |
| res_vld_i | input | 1 | `res_i` is valid |
| inv_i | input | 1 | 0 = forward (coefficients out), 1 = inverse (pixels out) |
| pix9_i | input | 1 | Pixel width: 0 = 8 bits, 1 = 9 bits |
| oe_i | input | 1 | Output-enable request |
| din_i | input | 12 | Input bus word |
| din_vld_i | input | 1 | `din_i` is valid |
| dout_o | output | 12 | Formatted output bus word |
| dout_vld_o | output | 1 | `dout_o` was updated this cycle |
| bus_en_o | output | 1 | Pad driver enable |
| sx_o | output | 16 | Sign-extended input value |
| sx_vld_o | output | 1 | `sx_o` was updated this cycle |

## Verification
Each mode is driven with several kinds of value:
- values well inside the range, which show that the value passes through untouched;
- values exactly at each limit and one step past it, which catch off-by-one errors in the saturation thresholds;
- values at the far ends of the 16-bit input, which catch a limit test that only looks at some of the high bits.

In inverse mode, checking the full bus word shows both that the pixel sits in the right bit positions and that the spare low bits are zero. Input bus words are sent twice, once with the low bits clear and once with them set, so that any leak from the ignored bits shows up. Idle cycles and toggling of the enable input check that the data holds when it should and that the enable path stays separate from the data.

// File: rtl/clip_fmt_pkg.sv
package clip_fmt_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_INV = 1'b1
  } xform_dir_e;

  typedef enum logic {
    PIXW_NARROW = 1'b0,
    PIXW_WIDE   = 1'b1
  } pix_width_e;
endpackage

// File: rtl/cf_sat.sv
// Saturates a signed IN_W-bit value to a signed OUT_W-bit value.
module cf_sat #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int HI_W = IN_W - OUT_W;  // number of bits above the kept sign bit

  logic             sgn;
  logic [HI_W-1:0]  upper;
  logic             pos_ovf;
  logic             neg_ovf;

  assign sgn     = val_i[IN_W-1];
  assign upper   = val_i[IN_W-2:OUT_W-1];
  assign pos_ovf = !sgn && (upper != '0);
  assign neg_ovf = sgn && (upper != '1);

  always_comb begin
    if (pos_ovf)      val_o = {1'b0, {(OUT_W-1){1'b1}}};
    else if (neg_ovf) val_o = {1'b1, {(OUT_W-1){1'b0}}};
    else              val_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/cf_outfmt.sv
// Clips the wide result for the active mode and places it on the bus.
module cf_outfmt
  import clip_fmt_pkg::*;
#(
  parameter int RES_W  = 16,
  parameter int BUS_W  = 12,
  parameter int PIX_NW = 8,
  parameter int PIX_WW = 9
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             inv_i,
  input  logic             pix9_i,
  output logic [BUS_W-1:0] word_o
);
  localparam int PAD_NW = BUS_W - PIX_NW;
  localparam int PAD_WW = BUS_W - PIX_WW;

  logic [BUS_W-1:0]  coef;
  logic [PIX_WW-1:0] pix_w;
  logic [PIX_NW-1:0] pix_n;
  xform_dir_e        dir;
  pix_width_e        pw;

  assign dir = xform_dir_e'(inv_i);
  assign pw  = pix_width_e'(pix9_i);

  cf_sat #(.IN_W(RES_W), .OUT_W(BUS_W))  u_sat_coef (.val_i(res_i), .val_o(coef));
  cf_sat #(.IN_W(RES_W), .OUT_W(PIX_WW)) u_sat_pixw (.val_i(res_i), .val_o(pix_w));
  cf_sat #(.IN_W(RES_W), .OUT_W(PIX_NW)) u_sat_pixn (.val_i(res_i), .val_o(pix_n));

  always_comb begin
    if (dir == DIR_FWD)       word_o = coef;
    else if (pw == PIXW_WIDE) word_o = {pix_w, {PAD_WW{1'b0}}};
    else                      word_o = {pix_n, {PAD_NW{1'b0}}};
  end
endmodule

// File: rtl/cf_infmt.sv
// Reads a pixel or a coefficient from the input bus and sign-extends it.
module cf_infmt
  import clip_fmt_pkg::*;
#(
  parameter int RES_W  = 16,
  parameter int BUS_W  = 12,
  parameter int PIX_NW = 8,
  parameter int PIX_WW = 9
) (
  input  logic [BUS_W-1:0] din_i,
  input  logic             inv_i,
  input  logic             pix9_i,
  output logic [RES_W-1:0] ext_o
);
  localparam int EXT_C = RES_W - BUS_W;
  localparam int EXT_W = RES_W - PIX_WW;
  localparam int EXT_N = RES_W - PIX_NW;

  logic [PIX_WW-1:0] top_w;
  logic [PIX_NW-1:0] top_n;

  assign top_w = din_i[BUS_W-1 -: PIX_WW];
  assign top_n = din_i[BUS_W-1 -: PIX_NW];

  always_comb begin
    if (xform_dir_e'(inv_i) == DIR_INV)
      ext_o = {{EXT_C{din_i[BUS_W-1]}}, din_i};
    else if (pix_width_e'(pix9_i) == PIXW_WIDE)
      ext_o = {{EXT_W{top_w[PIX_WW-1]}}, top_w};
    else
      ext_o = {{EXT_N{top_n[PIX_NW-1]}}, top_n};
  end
endmodule

// File: rtl/clip_fmt_top.sv
module clip_fmt_top #(
  parameter int RES_W  = 16,
  parameter int BUS_W  = 12,
  parameter int PIX_NW = 8,
  parameter int PIX_WW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RES_W-1:0] res_i,
  input  logic             res_vld_i,
  input  logic             inv_i,
  input  logic             pix9_i,
  input  logic             oe_i,
  input  logic [BUS_W-1:0] din_i,
  input  logic             din_vld_i,
  output logic [BUS_W-1:0] dout_o,
  output logic             dout_vld_o,
  output logic             bus_en_o,
  output logic [RES_W-1:0] sx_o,
  output logic             sx_vld_o
);
  logic [BUS_W-1:0] word;
  logic [RES_W-1:0] ext;

  cf_outfmt #(.RES_W(RES_W), .BUS_W(BUS_W), .PIX_NW(PIX_NW), .PIX_WW(PIX_WW)) u_outfmt (
    .res_i (res_i),
    .inv_i (inv_i),
    .pix9_i(pix9_i),
    .word_o(word)
  );

  cf_infmt #(.RES_W(RES_W), .BUS_W(BUS_W), .PIX_NW(PIX_NW), .PIX_WW(PIX_WW)) u_infmt (
    .din_i (din_i),
    .inv_i (inv_i),
    .pix9_i(pix9_i),
    .ext_o (ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o     <= '0;
      dout_vld_o <= 1'b0;
      bus_en_o   <= 1'b0;
      sx_o       <= '0;
      sx_vld_o   <= 1'b0;
    end else begin
      dout_vld_o <= res_vld_i;
      bus_en_o   <= oe_i;
      sx_vld_o   <= din_vld_i;
      if (res_vld_i) dout_o <= word;
      if (din_vld_i) sx_o   <= ext;
    end
  end
endmodule

// File: rtl/clip_fmt_chk.sv
module clip_fmt_chk #(
  parameter int RES_W = 16,
  parameter int BUS_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [RES_W-1:0] res_i,
  input logic             res_vld_i,
  input logic             inv_i,
  input logic             pix9_i,
  input logic             oe_i,
  input logic [BUS_W-1:0] dout_o,
  input logic             dout_vld_o,
  input logic             bus_en_o
);
  logic res_hi_pos;
  logic res_hi_neg;
  assign res_hi_pos = !res_i[RES_W-1] && (res_i[RES_W-2:BUS_W-1] != '0);
  assign res_hi_neg =  res_i[RES_W-1] && (res_i[RES_W-2:BUS_W-1] != '1);

  assert_fwd_pos_sat_R2: assert property (@(posedge clk) disable iff (rst)
    (res_vld_i && !inv_i && res_hi_pos) |=> (dout_o == {1'b0, {(BUS_W-1){1'b1}}}));

  assert_fwd_neg_sat_R2: assert property (@(posedge clk) disable iff (rst)
    (res_vld_i && !inv_i && res_hi_neg) |=> (dout_o == {1'b1, {(BUS_W-1){1'b0}}}));

  assert_pix8_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (res_vld_i && inv_i && !pix9_i) |=> (dout_o[3:0] == 4'h0));

  assert_pix9_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (res_vld_i && inv_i && pix9_i) |=> (dout_o[2:0] == 3'h0));

  assert_vld_follow_R5: assert property (@(posedge clk) disable iff (rst)
    res_vld_i |=> dout_vld_o);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !res_vld_i |=> (!dout_vld_o && $stable(dout_o)));

  assert_en_on_R6: assert property (@(posedge clk) disable iff (rst)
    oe_i |=> bus_en_o);

  assert_en_off_R6: assert property (@(posedge clk) disable iff (rst)
    !oe_i |=> !bus_en_o);
endmodule

bind clip_fmt_top clip_fmt_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .res_i     (res_i),
  .res_vld_i (res_vld_i),
  .inv_i     (inv_i),
  .pix9_i    (pix9_i),
  .oe_i      (oe_i),
  .dout_o    (dout_o),
  .dout_vld_o(dout_vld_o),
  .bus_en_o  (bus_en_o)
);

// File: tb/clip_fmt_top_tb.sv
`timescale 1ns/1ps
module clip_fmt_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] res_i = '0;
  logic        res_vld_i = 1'b0;
  logic        inv_i = 1'b0;
  logic        pix9_i = 1'b0;
  logic        oe_i = 1'b0;
  logic [11:0] din_i = '0;
  logic        din_vld_i = 1'b0;
  logic [11:0] dout_o;
  logic        dout_vld_o;
  logic        bus_en_o;
  logic [15:0] sx_o;
  logic        sx_vld_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  clip_fmt_top u_dut (
    .clk(clk), .rst(rst), .res_i(res_i), .res_vld_i(res_vld_i), .inv_i(inv_i),
    .pix9_i(pix9_i), .oe_i(oe_i), .din_i(din_i), .din_vld_i(din_vld_i),
    .dout_o(dout_o), .dout_vld_o(dout_vld_o), .bus_en_o(bus_en_o),
    .sx_o(sx_o), .sx_vld_o(sx_vld_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_bus(input int v, input bit inv, input bit p9);
    int lo, hi, sh, c;
    logic [31:0] t;
    if (!inv)    begin lo = -2048; hi = 2047; sh = 0; end
    else if (p9) begin lo = -256;  hi = 255;  sh = 3; end
    else         begin lo = -128;  hi = 127;  sh = 4; end
    c = (v > hi) ? hi : ((v < lo) ? lo : v);
    t = 32'(c) << sh;
    return t[11:0];
  endfunction

  // Apply one result, check the bus word one edge later.
  task automatic send_res(input int v, input bit inv, input bit p9, input string tag);
    @(negedge clk);
    res_i = 16'(v); inv_i = inv; pix9_i = p9; res_vld_i = 1'b1;
    @(posedge clk); #1;
    chk(dout_o == exp_bus(v, inv, p9), tag, {20'd0, dout_o}, {20'd0, exp_bus(v, inv, p9)});
    chk(dout_vld_o == 1'b1, {tag, " vld"}, {31'd0, dout_vld_o}, 32'd1);
    @(negedge clk);
    res_vld_i = 1'b0;
  endtask

  task automatic send_din(input logic [11:0] d, input bit inv, input bit p9,
                          input logic [15:0] exp, input string tag);
    @(negedge clk);
    din_i = d; inv_i = inv; pix9_i = p9; din_vld_i = 1'b1;
    @(posedge clk); #1;
    chk(sx_o == exp, tag, {16'd0, sx_o}, {16'd0, exp});
    chk(sx_vld_o == 1'b1, {tag, " vld"}, {31'd0, sx_vld_o}, 32'd1);
    @(negedge clk);
    din_vld_i = 1'b0;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    chk(dout_o == '0, "R7 dout", {20'd0, dout_o}, 32'd0);
    chk(!dout_vld_o && !bus_en_o && !sx_vld_o, "R7 flags",
        {29'd0, dout_vld_o, bus_en_o, sx_vld_o}, 32'd0);
    chk(sx_o == '0, "R7 sx", {16'd0, sx_o}, 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_fwd_pass;
    send_res(0, 0, 0, "R1 zero");
    send_res(1, 0, 0, "R1 one");
    send_res(-1, 0, 0, "R1 minus one");
    send_res(2047, 0, 0, "R1 max");
    send_res(-2048, 0, 0, "R1 min");
    send_res(1234, 0, 0, "R1 mid");
    send_res(-777, 0, 0, "R1 neg mid");
  endtask

  task automatic t_fwd_sat;
    send_res(2048, 0, 0, "R2 just over");
    send_res(32767, 0, 0, "R2 far over");
    send_res(-2049, 0, 0, "R2 just under");
    send_res(-32768, 0, 0, "R2 far under");
    send_res(4096, 0, 0, "R2 bit12");
  endtask

  task automatic t_fwd_pix9;
    send_res(-1000, 0, 1, "R11 pix9 ignored in");
    send_res(5000, 0, 1, "R11 pix9 ignored sat");
  endtask

  task automatic t_inv8;
    send_res(127, 1, 0, "R3 max");
    send_res(128, 1, 0, "R3 over");
    send_res(-128, 1, 0, "R3 min");
    send_res(-129, 1, 0, "R3 under");
    send_res(5, 1, 0, "R3 small");
    send_res(-5, 1, 0, "R3 small neg");
    send_res(-30000, 1, 0, "R3 far under");
  endtask

  task automatic t_inv9;
    send_res(255, 1, 1, "R4 max");
    send_res(256, 1, 1, "R4 over");
    send_res(-256, 1, 1, "R4 min");
    send_res(-257, 1, 1, "R4 under");
    send_res(200, 1, 1, "R4 mid");
    send_res(20000, 1, 1, "R4 far over");
  endtask

  task automatic t_hold;
    logic [11:0] prev;
    send_res(300, 0, 0, "R5 load");
    prev = dout_o;
    @(negedge clk);
    res_i = 16'd999; res_vld_i = 1'b0;
    @(posedge clk); #1;
    chk(dout_o == prev, "R5 hold", {20'd0, dout_o}, {20'd0, prev});
    chk(dout_vld_o == 1'b0, "R5 vld low", {31'd0, dout_vld_o}, 32'd0);
    @(posedge clk); #1;
    chk(dout_o == prev, "R5 hold2", {20'd0, dout_o}, {20'd0, prev});
  endtask

  task automatic t_oe;
    @(negedge clk); oe_i = 1'b1;
    @(posedge clk); #1;
    chk(bus_en_o == 1'b1, "R6 en on", {31'd0, bus_en_o}, 32'd1);
    @(negedge clk); oe_i = 1'b0;
    @(posedge clk); #1;
    chk(bus_en_o == 1'b0, "R6 en off", {31'd0, bus_en_o}, 32'd0);
    send_res(-600, 0, 0, "R6 data with oe low");
  endtask

  task automatic t_infmt;
    send_din(12'hA5F, 0, 0, 16'hFFA5, "R8 pix8");
    send_din(12'hA50, 0, 0, 16'hFFA5, "R8 pix8 low clear");
    send_din(12'h7F0, 0, 0, 16'h007F, "R8 pix8 pos");
    send_din(12'hA5F, 0, 1, 16'hFF4B, "R9 pix9");
    send_din(12'hA58, 0, 1, 16'hFF4B, "R9 pix9 low clear");
    send_din(12'h800, 1, 0, 16'hF800, "R10 coef min");
    send_din(12'h7FF, 1, 1, 16'h07FF, "R10 coef max");
    @(negedge clk); din_i = 12'h123;
    @(posedge clk); #1;
    chk(sx_o == 16'h07FF, "R10 hold", {16'd0, sx_o}, 32'h07FF);
    chk(sx_vld_o == 1'b0, "R10 vld low", {31'd0, sx_vld_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fwd_pass();
    t_fwd_sat();
    t_fwd_pix9();
    t_inv8();
    t_inv9();
    t_hold();
    t_oe();
    t_infmt();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule